// File: doc/BRIEF.md
# Power-On Boot Bus Jammer

This block gets a processor to a boot routine in high memory when no ROM answers at address zero. From reset it holds a status-disable output high, so the processor's own status drivers stay off the bus and the block owns it. It also answers memory reads itself, and while it does so it raises an inhibit output that keeps normal memory silent.

The block has two variants, chosen at elaboration. In the jump variant it answers the first three memory reads with a three-byte absolute jump to the target: the opcode byte C3H, then the target's low byte, then its high byte. In the slide variant it answers every memory read with the no-op byte 00H, so the processor's fetch address climbs one step per read. A comparator watches the fetch address, and when it equals the target the block stops answering, so real memory supplies that byte. In both variants the block then lets go of the bus for good, until the next reset.

The bus is described by a cycle kind code (`cyc_kind`: 00 idle, 01 memory read, 10 memory write, 11 I/O) and an address. A one-clock `cyc_end` pulse marks the final clock of each cycle. The controller `boot_jam_seq` has five named states:

- ST_OPCODE, ST_ADDR_LO, ST_ADDR_HI: the jump bytes.
- ST_SLIDE: the no-op slide.
- ST_RELEASED: terminal.

Its transitions are:

- OPCODE→ADDR_LO, ADDR_LO→ADDR_HI and ADDR_HI→RELEASED, each on the end of a memory read.
- SLIDE→RELEASED on the end of a memory read whose address equals the target.
- RELEASED has no exit except reset. Reset enters OPCODE in the jump variant and SLIDE in the slide variant.

Top module: `boot_jammer`

## Requirements
- R1: Right after reset, and in every later cycle until release, `status_off` is 1. With `cyc_kind` = 00, `data_oe` is 0.
- R2: In the jump variant, the first three memory reads (`cyc_kind` = 01) see `data_oe` = 1 with `data_out` equal to C3H, then the target's low byte, then its high byte.
- R3: In the jump variant, after the third memory read ends, `status_off`, `data_oe` and `inhibit_mem` are all 0 from the next clock on.
- R4: In the slide variant, every memory read at an address other than the target sees `data_oe` = 1 and `data_out` = 00H.
- R5: In the slide variant, a memory read at the target address sees `data_oe` = 0 and `inhibit_mem` = 0. From the clock after that read ends, `status_off` is 0.
- R6: Memory write (10) and I/O (11) cycles never see `data_oe` = 1 and do not advance the byte sequence or cause release, even at the target address.
- R7: Once released, the block stays released until reset. Later memory reads at any address, the target included, see `data_oe`, `inhibit_mem` and `status_off` all 0.
- R8: A new reset after release brings back the full boot behaviour from its first step.
- R9: `inhibit_mem` equals `data_oe` in every cycle. `data_out` is 00H whenever `data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_kind | input | 2 | Current bus cycle kind: 00 idle, 01 memory read, 10 memory write, 11 I/O |
| cyc_end | input | 1 | High on the last clock of the current bus cycle |
| cyc_addr | input | ADDR_W (16) | Address of the current bus cycle |
| status_off | output | 1 | Disable for the processor's status drivers; high while the block owns the bus |
| inhibit_mem | output | 1 | Tells normal memory to stay silent on this cycle |
| data_oe | output | 1 | Enable for the block's data drivers |
| data_out | output | DATA_W (8) | Byte the block supplies on the data bus |

## Verification
The bench places I/O and write cycles before and inside the boot sequence. A design that let them advance the sequence would put the wrong jump byte on the next read, or release the slide early.

The slide's last step reads at the exact target address. A comparator that released one read late would jam a no-op over the real first instruction, and one that released early would leave the processor short of the target.

After release the bench reads address zero and the target again. A design whose release was not sticky would resume driving the bus. A final reset checks that the sequence starts over from the opcode byte.

// File: rtl/boot_jam_pkg.sv
package boot_jam_pkg;

    typedef enum logic {
        JAM_JUMP,
        JAM_SLIDE
    } jam_mode_e;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR_LO,
        ST_ADDR_HI,
        ST_SLIDE,
        ST_RELEASED
    } jam_state_e;

    typedef enum logic [1:0] {
        CYC_IDLE   = 2'b00,
        CYC_MEM_RD = 2'b01,
        CYC_MEM_WR = 2'b10,
        CYC_IO     = 2'b11
    } cyc_kind_e;

endpackage

// File: rtl/boot_jam_match.sv
// Address comparator for the no-op slide: flags a fetch at the target.
module boot_jam_match #(
    parameter int unsigned      ADDR_W = 16,
    parameter logic [ADDR_W-1:0] TARGET = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb hit = (addr == TARGET);
endmodule

// File: rtl/boot_jam_seq.sv
// Boot sequence controller: state register only.
module boot_jam_seq
    import boot_jam_pkg::*;
#(
    parameter jam_mode_e MODE = JAM_JUMP
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_done,
    input  logic       hit,
    output jam_state_e state
);
    localparam jam_state_e START = (MODE == JAM_JUMP) ? ST_OPCODE : ST_SLIDE;

    jam_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OPCODE:   if (rd_done) nxt = ST_ADDR_LO;
            ST_ADDR_LO:  if (rd_done) nxt = ST_ADDR_HI;
            ST_ADDR_HI:  if (rd_done) nxt = ST_RELEASED;
            ST_SLIDE:    if (rd_done && hit) nxt = ST_RELEASED;
            ST_RELEASED: nxt = ST_RELEASED;
            default:     nxt = ST_RELEASED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= START;
        else        state <= nxt;
    end

    // R7: release is terminal until reset
    p_release_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASED) |=> (state == ST_RELEASED));

    // R6: cycles other than a finished memory read leave the state alone
    p_no_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |=> $stable(state));
endmodule

// File: rtl/boot_jam_drive.sv
// Output decode: what the block puts on the bus in each state.
module boot_jam_drive
    import boot_jam_pkg::*;
#(
    parameter int unsigned       ADDR_W = 16,
    parameter int unsigned       DATA_W = 8,
    parameter logic [ADDR_W-1:0] TARGET = '0,
    parameter logic [DATA_W-1:0] JMP_OP = 8'hC3,
    parameter logic [DATA_W-1:0] NOP_OP = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  jam_state_e        state,
    input  cyc_kind_e         kind,
    input  logic              hit,
    output logic              status_off,
    output logic              inhibit_mem,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_out
);
    localparam logic [DATA_W-1:0] TGT_LO = TARGET[DATA_W-1:0];
    localparam logic [DATA_W-1:0] TGT_HI = DATA_W'(TARGET >> DATA_W);

    logic              is_rd;
    logic [DATA_W-1:0] byte_sel;

    always_comb begin
        is_rd      = (kind == CYC_MEM_RD);
        status_off = 1'b1;
        data_oe    = 1'b0;
        byte_sel   = '0;
        unique case (state)
            ST_OPCODE:  begin data_oe = is_rd;        byte_sel = JMP_OP; end
            ST_ADDR_LO: begin data_oe = is_rd;        byte_sel = TGT_LO; end
            ST_ADDR_HI: begin data_oe = is_rd;        byte_sel = TGT_HI; end
            ST_SLIDE:   begin data_oe = is_rd && !hit; byte_sel = NOP_OP; end
            default:    begin status_off = 1'b0; end
        endcase
        inhibit_mem = data_oe;
        data_out    = data_oe ? byte_sel : '0;
    end

    // R9: memory is inhibited on every byte the block supplies
    p_oe_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> inhibit_mem);

    // R6: the drivers open only during memory reads
    p_drive_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (kind == CYC_MEM_RD));

    // R7: after release nothing is driven
    p_quiet_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !status_off |-> (!data_oe && !inhibit_mem));
endmodule

// File: rtl/boot_jammer.sv
module boot_jammer
    import boot_jam_pkg::*;
#(
    parameter int unsigned       ADDR_W = 16,
    parameter int unsigned       DATA_W = 8,
    parameter jam_mode_e         MODE   = JAM_JUMP,
    parameter logic [ADDR_W-1:0] TARGET = 16'hF800,
    parameter logic [DATA_W-1:0] JMP_OP = 8'hC3,
    parameter logic [DATA_W-1:0] NOP_OP = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cyc_kind,
    input  logic              cyc_end,
    input  logic [ADDR_W-1:0] cyc_addr,
    output logic              status_off,
    output logic              inhibit_mem,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_out
);
    cyc_kind_e  kind;
    logic       hit;
    logic       rd_done;
    jam_state_e state;

    always_comb begin
        kind    = cyc_kind_e'(cyc_kind);
        rd_done = cyc_end && (kind == CYC_MEM_RD);
    end

    boot_jam_match #(.ADDR_W(ADDR_W), .TARGET(TARGET)) u_match (
        .addr (cyc_addr),
        .hit  (hit)
    );

    boot_jam_seq #(.MODE(MODE)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_done (rd_done),
        .hit     (hit),
        .state   (state)
    );

    boot_jam_drive #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TARGET(TARGET),
        .JMP_OP(JMP_OP), .NOP_OP(NOP_OP)
    ) u_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .kind        (kind),
        .hit         (hit),
        .status_off  (status_off),
        .inhibit_mem (inhibit_mem),
        .data_oe     (data_oe),
        .data_out    (data_out)
    );

    // R5: a slide fetch at the target is never jammed
    p_target_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == JAM_SLIDE && hit && kind == CYC_MEM_RD) |-> !data_oe);
endmodule

// File: tb/test_boot_jammer.sv
module test_boot_jammer;
    import boot_jam_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] TGT_J = 16'hF800;
    localparam logic [15:0] TGT_S = 16'h0004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cyc_kind = 2'b00;
    logic        cyc_end = 1'b0;
    logic [15:0] cyc_addr = '0;
    logic        sel = 1'b0;   // 0: jump instance, 1: slide instance

    logic       st_j, inh_j, oe_j, st_s, inh_s, oe_s;
    logic [7:0] d_j, d_s;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_jammer #(.MODE(JAM_JUMP), .TARGET(TGT_J)) i_boot_jammer (
        .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .cyc_end(cyc_end & ~sel),
        .cyc_addr(cyc_addr), .status_off(st_j), .inhibit_mem(inh_j),
        .data_oe(oe_j), .data_out(d_j)
    );

    boot_jammer #(.MODE(JAM_SLIDE), .TARGET(TGT_S)) i_boot_jammer_slide (
        .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .cyc_end(cyc_end & sel),
        .cyc_addr(cyc_addr), .status_off(st_s), .inhibit_mem(inh_s),
        .data_oe(oe_s), .data_out(d_s)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sampled view of the selected instance: {status, inhibit, oe, data}
    function automatic logic [10:0] view();
        return sel ? {st_s, inh_s, oe_s, d_s} : {st_j, inh_j, oe_j, d_j};
    endfunction

    // One single-clock bus cycle; checks outputs mid-cycle
    task automatic bus(input logic [1:0] k, input logic [15:0] a,
                       input string req, input logic [10:0] exp);
        @(negedge clk);
        cyc_kind = k; cyc_addr = a; cyc_end = 1'b1;
        #1;
        check(req, {5'd0, view()}, {5'd0, exp});
        @(posedge clk);
        @(negedge clk);
        cyc_kind = 2'b00; cyc_end = 1'b0;
    endtask

    task automatic idle_check(input string req, input logic [10:0] exp);
        @(negedge clk);
        #1;
        check(req, {5'd0, view()}, {5'd0, exp});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cyc_kind = 2'b00; cyc_end = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        sel = 1'b0; idle_check("R1 jump reset", {1'b1, 1'b0, 1'b0, 8'h00});
        sel = 1'b1; idle_check("R1 slide reset", {1'b1, 1'b0, 1'b0, 8'h00});
    endtask

    task automatic t_jump();
        sel = 1'b0;
        bus(2'b11, 16'h0000, "R6 io before jump", {1'b1, 1'b0, 1'b0, 8'h00});
        bus(2'b10, 16'h0000, "R6 write before jump", {1'b1, 1'b0, 1'b0, 8'h00});
        bus(2'b01, 16'h0000, "R2 opcode byte", {1'b1, 1'b1, 1'b1, 8'hC3});
        bus(2'b11, 16'h0001, "R6 io inside jump", {1'b1, 1'b0, 1'b0, 8'h00});
        bus(2'b01, 16'h0001, "R2 low byte", {1'b1, 1'b1, 1'b1, TGT_J[7:0]});
        bus(2'b01, 16'h0002, "R2 high byte R9", {1'b1, 1'b1, 1'b1, TGT_J[15:8]});
        idle_check("R3 released after jump", {1'b0, 1'b0, 1'b0, 8'h00});
        bus(2'b01, 16'h0000, "R7 read zero after release", {1'b0, 1'b0, 1'b0, 8'h00});
        bus(2'b01, TGT_J, "R7 read target after release", {1'b0, 1'b0, 1'b0, 8'h00});
    endtask

    task automatic t_slide();
        sel = 1'b1;
        for (int i = 0; i < 4; i++) begin
            bus(2'b01, 16'(i), "R4 slide nop", {1'b1, 1'b1, 1'b1, 8'h00});
            if (i == 1) begin
                bus(2'b11, TGT_S, "R6 io at target", {1'b1, 1'b0, 1'b0, 8'h00});
                bus(2'b10, TGT_S, "R6 write at target", {1'b1, 1'b0, 1'b0, 8'h00});
            end
        end
        bus(2'b01, TGT_S, "R5 target read free R9", {1'b1, 1'b0, 1'b0, 8'h00});
        idle_check("R5 released after target", {1'b0, 1'b0, 1'b0, 8'h00});
        bus(2'b01, 16'h0000, "R7 slide read after release", {1'b0, 1'b0, 1'b0, 8'h00});
    endtask

    task automatic t_rereset();
        do_reset();
        sel = 1'b1; idle_check("R8 slide active again", {1'b1, 1'b0, 1'b0, 8'h00});
        sel = 1'b0;
        bus(2'b01, 16'h0000, "R8 jump restarts at opcode", {1'b1, 1'b1, 1'b1, 8'hC3});
    endtask

    initial begin
        t_reset();
        t_jump();
        t_slide();
        t_rereset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule